// File: doc/BRIEF.md
# Priority interrupt request comparator

This block takes interrupt requests from a parameterised set of devices. By default there are eight devices, and each device carries a 3-bit urgency level. A per-device enable bit masks each request. Among the requests that are both raised and enabled, the block finds the most urgent one. It then checks that request's level against the level of the program the processor is running now.

The block asserts one interrupt line only when the winning request is strictly more urgent than that running level. Together with the line it gives the winning device number and that device's level. All three outputs come from registers and are recomputed on every clock edge. The processor samples the line at its instruction boundary, after the store phase of one instruction and before the fetch of the next. When the line is low, the processor simply continues.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `irq_valid`, `irq_src` and `irq_lvl` are all zero.
- R2: A device takes part in arbitration only when its `req` bit and its `en` bit are both 1. A request whose enable is 0 never causes an interrupt.
- R3: Among the devices taking part, the one with the numerically largest level wins. Level 7 is the most urgent and level 0 the least.
- R4: `irq_valid` is 1 only when the winning level is strictly greater than `cur_lvl`. A winning level equal to `cur_lvl` does not interrupt, so with `cur_lvl` = 7 no interrupt is ever raised.
- R5: When several taking-part devices share the highest level, the one with the lowest device index wins.
- R6: The outputs are registered. The values seen after a clock edge reflect the inputs present at that edge, one cycle of latency.
- R7: When `irq_valid` is 0, `irq_src` and `irq_lvl` are both 0. When it is 1, they hold the winner's index and level.
- R8: The level of device i is carried in `src_lvl[3*i+2:3*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | One request bit per device |
| en | input | 8 | One enable bit per device |
| src_lvl | input | 24 | Packed 3-bit level per device, device i at [3i+2:3i] |
| cur_lvl | input | 3 | Level of the running program |
| irq_valid | output | 1 | Interrupt signal to the processor |
| irq_src | output | 3 | Index of the winning device |
| irq_lvl | output | 3 | Level of the winning device |

## Verification
Directed patterns separate the decisions the block makes. A lone device shows that the output is mapped to the right place. Distinct levels across all devices exercise the maximum search. Duplicate top levels expose a wrong tie-break direction. Requests that are raised but masked catch an enable that is ignored.

Sweeps of `cur_lvl` step from just below the winning level, to equal to it, and then above it. A `>=` comparison slipped in where `>` is meant fails only at the equal step, so that step tells the two apart.

A long run of random requests, enables and levels is checked cycle by cycle against a behavioural model. This run catches errors in latency and in field slicing that the directed cases might not reach.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int unsigned DEF_SRC   = 8;
   localparam int unsigned DEF_LVL_W = 3;
endpackage

// File: rtl/irq_mask.sv
module irq_mask #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] req,
   input  logic [N-1:0] en,
   output logic [N-1:0] live
);
   for (genvar i = 0; i < N; i++) begin : g_src
      assign live[i] = req[i] & en[i];
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned N    = 8,
   parameter int unsigned LW   = 3,
   localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    live,
   input  logic [N*LW-1:0] lvl_vec,
   output logic            any,
   output logic [IW-1:0]   idx,
   output logic [LW-1:0]   lvl
);
   // Scan from the top index downwards; ">=" lets a lower index take over a tie.
   always_comb begin
      any = 1'b0;
      idx = '0;
      lvl = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (live[i] && (!any || lvl_vec[i*LW +: LW] >= lvl)) begin
            any = 1'b1;
            idx = IW'(i);
            lvl = lvl_vec[i*LW +: LW];
         end
      end
   end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int unsigned LW = 3,
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any,
   input  logic [IW-1:0] idx,
   input  logic [LW-1:0] lvl,
   input  logic [LW-1:0] cur_lvl,
   output logic          irq_valid,
   output logic [IW-1:0] irq_src,
   output logic [LW-1:0] irq_lvl
);
   logic fire;
   assign fire = any && (lvl > cur_lvl);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_src   <= '0;
         irq_lvl   <= '0;
      end else begin
         irq_valid <= fire;
         irq_src   <= fire ? idx : '0;
         irq_lvl   <= fire ? lvl : '0;
      end
   end

   // R6
   fire_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any && lvl > cur_lvl) |=> irq_valid);

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_src == '0 && irq_lvl == '0));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC = DEF_SRC,
   parameter int unsigned LVL_W   = DEF_LVL_W,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       req,
   input  logic [NUM_SRC-1:0]       en,
   input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
   input  logic [LVL_W-1:0]         cur_lvl,
   output logic                     irq_valid,
   output logic [IDX_W-1:0]         irq_src,
   output logic [LVL_W-1:0]         irq_lvl
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_prio_arbiter: NUM_SRC must be at least 2");
   end
   if (LVL_W < 1) begin : g_bad_lvl
      $error("irq_prio_arbiter: LVL_W must be at least 1");
   end

   logic [NUM_SRC-1:0] live;
   logic               win_any;
   logic [IDX_W-1:0]   win_idx;
   logic [LVL_W-1:0]   win_lvl;

   irq_mask #(.N(NUM_SRC)) u_mask (
      .req  (req),
      .en   (en),
      .live (live)
   );

   irq_pick #(.N(NUM_SRC), .LW(LVL_W)) u_pick (
      .live    (live),
      .lvl_vec (src_lvl),
      .any     (win_any),
      .idx     (win_idx),
      .lvl     (win_lvl)
   );

   irq_gate #(.LW(LVL_W), .IW(IDX_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .any       (win_any),
      .idx       (win_idx),
      .lvl       (win_lvl),
      .cur_lvl   (cur_lvl),
      .irq_valid (irq_valid),
      .irq_src   (irq_src),
      .irq_lvl   (irq_lvl)
   );

   // R4
   outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!irq_valid || irq_lvl > $past(cur_lvl)));

   // R2
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live == '0) |=> !irq_valid);
endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req = '0;
   logic [7:0]  en = '0;
   logic [23:0] src_lvl = '0;
   logic [2:0]  cur_lvl = '0;
   logic        irq_valid;
   logic [2:0]  irq_src;
   logic [2:0]  irq_lvl;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int exp_v = 0, exp_s = 0, exp_l = 0;

   always #10 clk = ~clk;

   irq_prio_arbiter uut (
      .clk(clk), .rst_n(rst_n), .req(req), .en(en), .src_lvl(src_lvl),
      .cur_lvl(cur_lvl), .irq_valid(irq_valid), .irq_src(irq_src), .irq_lvl(irq_lvl)
   );

   // Behavioural reference: strict ">" while scanning upward keeps the first (lowest) index.
   always @(posedge clk) begin
      int best, bi;
      best = -1; bi = 0;
      if (!rst_n) begin
         exp_v = 0; exp_s = 0; exp_l = 0;
      end else begin
         for (int i = 0; i < 8; i++) begin
            int lv;
            lv = (src_lvl >> (3 * i)) & 7;
            if (req[i] && en[i] && lv > best) begin
               best = lv; bi = i;
            end
         end
         if (best > int'(cur_lvl)) begin
            exp_v = 1; exp_s = bi; exp_l = best;
         end else begin
            exp_v = 0; exp_s = 0; exp_l = 0;
         end
      end
   end

   task automatic compare(input string tag, input int ev, input int es, input int el);
      checks++;
      if (int'(irq_valid) != ev || int'(irq_src) != es || int'(irq_lvl) != el) begin
         errors++;
         $display("FAIL %s: got v=%0d src=%0d lvl=%0d, expected v=%0d src=%0d lvl=%0d",
                  tag, irq_valid, irq_src, irq_lvl, ev, es, el);
      end
   endtask

   // Drives at a falling edge, then checks against both model and hand value at the next one.
   task automatic step(input string tag, input logic [7:0] r, input logic [7:0] e,
                       input logic [23:0] l, input logic [2:0] c,
                       input int ev, input int es, input int el);
      req = r; en = e; src_lvl = l; cur_lvl = c;
      @(negedge clk);
      compare({tag, " model"}, exp_v, exp_s, exp_l);
      if (ev >= 0) compare(tag, ev, es, el);
   endtask

   function automatic logic [23:0] pack(input int l7, l6, l5, l4, l3, l2, l1, l0);
      return {l7[2:0], l6[2:0], l5[2:0], l4[2:0], l3[2:0], l2[2:0], l1[2:0], l0[2:0]};
   endfunction

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      req = 8'hFF; en = 8'hFF; src_lvl = {8{3'd7}};
      @(negedge clk);
      compare("R1 in reset", 0, 0, 0);
      rst_n = 1'b1;
      req = '0; en = '0; src_lvl = '0;
      @(negedge clk);
      compare("R1 after reset", 0, 0, 0);

      step("R2 all masked", 8'hFF, 8'h00, pack(7,7,7,7,7,7,7,7), 3'd0, 0, 0, 0);
      step("R2 enable without req", 8'h00, 8'hFF, pack(7,7,7,7,7,7,7,7), 3'd0, 0, 0, 0);
      step("R2 only enabled one counts", 8'h81, 8'h01, pack(7,0,0,0,0,0,0,3), 3'd1, 1, 0, 3);
      step("R3 single device", 8'h20, 8'hFF, pack(0,0,4,0,0,0,0,0), 3'd2, 1, 5, 4);
      step("R3 distinct levels", 8'hFF, 8'hFF, pack(1,3,0,6,2,5,4,7) ^ pack(0,0,0,0,0,0,0,0), 3'd0, 1, 0, 7);
      step("R3 max in middle", 8'hFF, 8'hFF, pack(1,3,0,6,2,5,4,0), 3'd0, 1, 4, 6);
      step("R4 cur one below", 8'h10, 8'hFF, pack(0,0,0,5,0,0,0,0), 3'd4, 1, 4, 5);
      step("R4 cur equal", 8'h10, 8'hFF, pack(0,0,0,5,0,0,0,0), 3'd5, 0, 0, 0);
      step("R4 cur above", 8'h10, 8'hFF, pack(0,0,0,5,0,0,0,0), 3'd6, 0, 0, 0);
      step("R4 cur seven", 8'hFF, 8'hFF, pack(7,7,7,7,7,7,7,7), 3'd7, 0, 0, 0);
      step("R4 level zero vs zero", 8'h01, 8'h01, pack(0,0,0,0,0,0,0,0), 3'd0, 0, 0, 0);
      step("R5 tie two", 8'h24, 8'hFF, pack(0,0,6,0,0,6,0,0), 3'd1, 1, 2, 6);
      step("R5 tie all", 8'hFF, 8'hFF, pack(3,3,3,3,3,3,3,3), 3'd0, 1, 0, 3);
      step("R5 tie masked low", 8'hFF, 8'hFE, pack(3,3,3,3,3,3,3,3), 3'd0, 1, 1, 3);
      step("R8 top field", 8'h80, 8'h80, pack(6,0,0,0,0,0,0,0), 3'd0, 1, 7, 6);
      step("R8 field one", 8'h02, 8'h02, 24'o00000020, 3'd1, 1, 1, 2);
      step("R7 drop to idle", 8'h00, 8'h00, '0, 3'd0, 0, 0, 0);

      // R6: a one-cycle pulse appears exactly one edge later, then clears
      req = 8'h08; en = 8'h08; src_lvl = pack(0,0,0,0,5,0,0,0); cur_lvl = 3'd0;
      @(negedge clk);
      compare("R6 pulse seen", 1, 3, 5);
      req = '0;
      @(negedge clk);
      compare("R6 pulse gone", 0, 0, 0);

      for (int k = 0; k < 400; k++) begin
         step("R6 random", 8'($urandom), 8'($urandom), 24'($urandom), 3'($urandom),
              -1, 0, 0);
      end

      rst_n = 1'b0;
      req = 8'hFF; en = 8'hFF; src_lvl = {8{3'd7}}; cur_lvl = 3'd0;
      @(negedge clk);
      compare("R1 mid-run reset", 0, 0, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule